// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block drives one pulse-width modulated output. Software programs a period and a set of control fields through a small register port. It then streams duty values into a four-deep sample queue. A prescaler divides the selected tick input. Each prescaled tick advances a period counter, and the counter's value compared against the active sample sets the output level. At each period boundary the block can take the next sample from the queue. How often it does so depends on a per-sample repeat count. When the queue has run dry, the last sample stays in use.

The register port is a single-cycle valid/write/address/data interface. Reads are combinational from the addressed register. The three clock sources are modelled as clock-enable tick inputs. A self-clearing software reset returns the whole block to its reset state, and status flags report queue events, period rollover and compare matches.

Top module: `fifo_pwm_gen`

## Requirements
- R1: Registers are decoded on the full byte address: control at 0x00, status at 0x04, sample at 0x0C and period at 0x10. After reset, control reads 0, status reads 0, sample reads 0 and period reads 0xFFFE. The period register reads back whatever value was written to it.
- R2: While running, one output period lasts (P+2) prescaled ticks, where P is the period value in effect. A period value of 0xFFFF gives the same length as 0xFFFE.
- R3: Control bits 15:4 hold D. One prescaled tick occurs every D+1 ticks of the selected source, for any D from 0 to 4095.
- R4: In normal mode (control bits 19:18 = 0), the output is high for min(S, P+2) prescaled ticks at the start of each period, where S is the active sample.
- R5: Mode 1 inverts the normal waveform. Modes 2 and 3 hold the output low. While control bit 0 (enable) is clear, the output is low in every mode.
- R6: Control bits 2:1 = k make each sample last 2^k periods. Samples are used in the order written. When the queue is empty at a sample boundary, the last sample is reused.
- R7: Control bits 17:16 = 0 stop the counter. A value n of 1 to 3 counts ticks of tick input n-1. A selected input held low also stops counting.
- R8: Status bits 2:0 give the queue occupancy, from 0 to 4. A sample write while the queue holds 4 entries is dropped and sets status bit 6.
- R9: Status bit 4 sets when a period ends and bit 5 when the counter equals the active sample on a prescaled tick. Bit 3 sets while enabled with occupancy at or below the watermark in control bits 27:26. Writing 1 to any of bits 6:3 clears that bit, but a bit whose set condition still holds sets again.
- R10: The sample register reads the active sample while enabled and 0 while disabled.
- R11: Writing control with bit 3 set makes bit 3 read 1 for one cycle. On the next clock edge every register, the queue and the counter return to their reset values. All other fields of that write are discarded.
- R12: A period value written while running takes effect at the next period boundary. The period in progress finishes at its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| src_tick | input | 3 | Clock-enable ticks of the three selectable sources |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest state to reach is a sample boundary that falls while a period change, a repeat count or an empty queue is pending. In that state several pieces of state switch on the same prescaled tick. To get there, the bench preloads the queue before enabling, so the order of pops is known. It captures the output cycle by cycle, aligns on the first high cycle and sums each period's high time separately. A period write is placed one cycle after a rising edge, so the current period and the next one each show their own length. Together with a sweep over prescaler, period, sample and mode, this separates the sample-switch point from the period-load point.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] A_SMPL = 5'h0C;
  localparam logic [ADDR_W-1:0] A_PERD = 5'h10;
  localparam int PRE_W = 12;
  localparam int SWR_BIT = 3;

  typedef enum logic [1:0] {
    OM_NORMAL = 2'd0,
    OM_INVERT = 2'd1,
    OM_LOW    = 2'd2,
    OM_LOW2   = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic [1:0]       wm;
    out_mode_e        mode;
    logic [1:0]       src;
    logic [PRE_W-1:0] pre;
    logic [1:0]       rep;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int NSRC  = 3,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [1:0]       src_sel,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [PRE_W-1:0] div_m1,
  output logic             pclk
);
  logic             tick;
  logic [PRE_W-1:0] pc_q, pc_d;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_sel == 2'(i + 1)) tick = src_tick[i];
  end

  assign pclk = run & ~clr & tick & (pc_q == div_m1);

  always_comb begin
    pc_d = pc_q;
    if (!run || clr)      pc_d = '0;
    else if (tick)        pc_d = (pc_q == div_m1) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             full,
  output logic             empty,
  output logic [OCC_W-1:0] occ
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign empty   = (occ_q == '0);
  assign occ     = occ_q;
  assign rdata   = mem[rp_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_d  = do_push ? inc(wp_q) : wp_q;
    rp_d  = do_pop  ? inc(rp_q) : rp_q;
    occ_d = occ_q;
    if (do_push && !do_pop)      occ_d = occ_q + 1'b1;
    else if (do_pop && !do_push) occ_d = occ_q - 1'b1;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      occ_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
  import pwm_gen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         pclk,
  input  logic [W-1:0] per_reg,
  input  logic [1:0]   rep_sel,
  input  out_mode_e    mode,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_pop,
  output logic         running,
  output logic [W-1:0] act_smp,
  output logic [W-1:0] cnt,
  output logic         roll_evt,
  output logic         cmp_evt,
  output logic         pwm_out
);
  localparam logic [W-1:0] PER_CAP = {{(W-1){1'b1}}, 1'b0};

  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d, aper_q, aper_d, act_q, act_d;
  logic [2:0]   rc_q, rc_d, reps_m1;
  logic [W-1:0] per_clamped, per_end;
  logic         last, take, level;

  assign per_clamped = (&per_reg) ? PER_CAP : per_reg;
  assign per_end     = aper_q + 1'b1;
  assign last        = (cnt_q == per_end);

  always_comb begin
    case (rep_sel)
      2'd0:    reps_m1 = 3'd0;
      2'd1:    reps_m1 = 3'd1;
      2'd2:    reps_m1 = 3'd3;
      default: reps_m1 = 3'd7;
    endcase
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    aper_d = aper_q;
    rc_d   = rc_q;
    act_d  = act_q;
    take   = 1'b0;
    if (!en) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      rc_d   = '0;
      aper_d = per_clamped;
    end else if (pclk) begin
      if (!run_q) begin
        run_d  = 1'b1;
        cnt_d  = '0;
        rc_d   = '0;
        aper_d = per_clamped;
        take   = 1'b1;
      end else if (last) begin
        cnt_d  = '0;
        aper_d = per_clamped;
        if (rc_q == reps_m1) begin
          rc_d = '0;
          take = 1'b1;
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    fifo_pop = take & ~fifo_empty;
    if (fifo_pop) act_d = fifo_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      aper_q <= PER_CAP;
      rc_q   <= '0;
      act_q  <= '0;
    end else if (clr) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      aper_q <= PER_CAP;
      rc_q   <= '0;
      act_q  <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      aper_q <= aper_d;
      rc_q   <= rc_d;
      act_q  <= act_d;
    end
  end

  assign level    = (cnt_q < act_q);
  assign roll_evt = en & pclk & run_q & last;
  assign cmp_evt  = en & pclk & run_q & (cnt_q == act_q);
  assign running  = run_q;
  assign act_smp  = act_q;
  assign cnt      = cnt_q;

  always_comb begin
    pwm_out = 1'b0;
    if (run_q) begin
      case (mode)
        OM_NORMAL: pwm_out = level;
        OM_INVERT: pwm_out = ~level;
        default:   pwm_out = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_pwm_gen.sv
module fifo_pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int NSRC       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic              pwm_out
);
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [DATA_W-1:0] PER_RST = {{(DATA_W-1){1'b1}}, 1'b0};

  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] per_q, per_d;
  logic [3:0]        flags_q, flags_d, flag_set, flag_clr;
  logic              swr_q, swr_d;
  logic              wr, wr_ctrl, wr_stat, wr_smpl, wr_perd;
  logic              fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [OCC_W-1:0]  fifo_occ;
  logic [DATA_W-1:0] fifo_data, act_smp, core_cnt;
  logic              pclk, core_running, roll_evt, cmp_evt;

  assign wr      = bus_valid & bus_write;
  assign wr_ctrl = wr & (bus_addr == A_CTRL);
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_smpl = wr & (bus_addr == A_SMPL);
  assign wr_perd = wr & (bus_addr == A_PERD);
  assign fifo_push = wr_smpl & ~fifo_full;

  always_comb begin
    ctrl_d = ctrl_q;
    swr_d  = 1'b0;
    per_d  = per_q;
    if (wr_ctrl) begin
      if (bus_wdata[SWR_BIT]) begin
        swr_d = 1'b1;
      end else begin
        ctrl_d.en   = bus_wdata[0];
        ctrl_d.rep  = bus_wdata[2:1];
        ctrl_d.pre  = bus_wdata[15:4];
        ctrl_d.src  = bus_wdata[17:16];
        ctrl_d.mode = out_mode_e'(bus_wdata[19:18]);
        ctrl_d.wm   = bus_wdata[27:26];
      end
    end
    if (wr_perd) per_d = bus_wdata[DATA_W-1:0];
    flag_set = {wr_smpl & fifo_full, cmp_evt, roll_evt,
                ctrl_q.en & (fifo_occ <= OCC_W'(ctrl_q.wm))};
    flag_clr = wr_stat ? bus_wdata[6:3] : 4'b0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      per_q   <= PER_RST;
      flags_q <= '0;
      swr_q   <= 1'b0;
    end else if (swr_q) begin
      ctrl_q  <= '0;
      per_q   <= PER_RST;
      flags_q <= '0;
      swr_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      per_q   <= per_d;
      flags_q <= flags_d;
      swr_q   <= swr_d;
    end
  end

  pwm_tick_div #(.NSRC(NSRC), .PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .clr(swr_q), .run(ctrl_q.en),
    .src_sel(ctrl_q.src), .src_tick(src_tick), .div_m1(ctrl_q.pre),
    .pclk(pclk)
  );

  pwm_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .clr(swr_q), .push(fifo_push),
    .wdata(bus_wdata[DATA_W-1:0]), .pop(fifo_pop), .rdata(fifo_data),
    .full(fifo_full), .empty(fifo_empty), .occ(fifo_occ)
  );

  pwm_period_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .clr(swr_q), .en(ctrl_q.en),
    .pclk(pclk), .per_reg(per_q), .rep_sel(ctrl_q.rep), .mode(ctrl_q.mode),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .running(core_running), .act_smp(act_smp), .cnt(core_cnt),
    .roll_evt(roll_evt), .cmp_evt(cmp_evt), .pwm_out(pwm_out)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {4'b0, ctrl_q.wm, 6'b0, ctrl_q.mode, ctrl_q.src,
                            ctrl_q.pre, swr_q, ctrl_q.rep, ctrl_q.en};
      A_STAT:  bus_rdata = {25'b0, flags_q, 3'(fifo_occ)};
      A_SMPL:  bus_rdata = ctrl_q.en ? 32'(act_smp) : 32'b0;
      A_PERD:  bus_rdata = 32'(per_q);
      default: bus_rdata = 32'b0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:28], bus_wdata[25:20], core_cnt, core_running};
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic [1:0]       src,
  input logic             swr,
  input logic             smp_wr,
  input logic             fifo_full,
  input logic             fifo_pop,
  input logic [OCC_W-1:0] occ,
  input logic             fwe_flag,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     aper,
  input logic             pwm_out
);
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_wr && fifo_full && !fifo_pop && !swr) |=> (occ == OCC_W'(DEPTH) && fwe_flag)); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !pwm_out); // R5
  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> !pwm_out); // R5
  AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0 && en && !swr) |=> $stable(cnt)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} <= {1'b0, aper} + 1'b1)); // R2
  AST_PER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    aper != '1); // R2
  AST_SWR_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (!swr && !en && occ == '0)); // R11
endmodule

bind fifo_pwm_gen pwm_gen_checker #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(ctrl_q.en), .mode(ctrl_q.mode),
  .src(ctrl_q.src), .swr(swr_q), .smp_wr(wr_smpl), .fifo_full(fifo_full),
  .fifo_pop(fifo_pop), .occ(fifo_occ), .fwe_flag(flags_q[3]),
  .cnt(core_cnt), .aper(u_core.aper_q), .pwm_out(pwm_out)
);

// File: tb/test_fifo_pwm_gen.sv
module test_fifo_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = 5'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [2:0]  src_tick = 3'b111;
  logic        pwm_out;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic cap [0:127];

  localparam logic [4:0] CT = 5'h00, ST = 5'h04, SM = 5'h0C, PE = 5'h10;

  fifo_pwm_gen i_fifo_pwm_gen (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cw(int en, int rep, int pre, int src, int mode, int wm);
    return 32'((en & 1) | ((rep & 3) << 1) | ((pre & 12'hFFF) << 4) |
               ((src & 3) << 16) | ((mode & 3) << 18) | ((wm & 3) << 26));
  endfunction

  task automatic soft_reset();
    logic [31:0] d;
    wr(CT, 32'h8);
    for (int i = 0; i < 5; i++) begin
      rd(CT, d);
      if (d[3] == 1'b0) break;
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic wait_rise(output int t);
    logic prev;
    @(negedge clk);
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (!prev && pwm_out) break;
      prev = pwm_out;
    end
    t = cyc;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < 128; i++) cap[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap[i] = pwm_out;
    end
  endtask

  function automatic int period_high(int t, int k);
    int i0 = -1;
    int h = 0;
    for (int i = 0; i < 128; i++) if (i0 < 0 && cap[i]) i0 = i;
    if (i0 < 0) return -1;
    for (int j = 0; j < t; j++)
      if (i0 + k * t + j < 128) h += int'(cap[i0 + k * t + j]);
    return h;
  endfunction

  initial begin
    logic [31:0] d;
    int h, t0, t1, t2, tp, hi, ex, per;
    int expa [7];
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    rd(CT, d); check("R1 ctrl reset", d, 32'h0);
    rd(ST, d); check("R1 status reset", d, 32'h0);
    rd(SM, d); check("R1 sample reset", d, 32'h0);
    rd(PE, d); check("R1 period reset", d, 32'hFFFE);
    wr(PE, 32'hFFFF); rd(PE, d); check("R1 period readback", d, 32'hFFFF);
    wr(5'h08, 32'h1234); rd(5'h08, d); check("R1 unmapped reads zero", d, 32'h0);

    // R4 R5 R3 R2: sweep of prescaler, period, sample and mode
    for (int pi = 0; pi < 3; pi++) begin
      for (int pv = 0; pv < 3; pv++) begin
        for (int md = 0; md < 3; md++) begin
          per = (pv == 2) ? 3 : pv;
          for (int s = 0; s <= per + 3; s++) begin
            soft_reset();
            wr(PE, 32'(per));
            wr(SM, 32'(s));
            wr(CT, cw(1, 0, pi, 1, md, 0));
            tp = (per + 2) * (pi + 1);
            repeat (2 * tp + 4) @(negedge clk);
            count_high(2 * tp, h);
            hi = ((s < per + 2) ? s : per + 2) * (pi + 1);
            ex = (md == 0) ? 2 * hi : (md == 1) ? 2 * tp - 2 * hi : 0;
            check($sformatf("R4/R5 sweep pre=%0d per=%0d mode=%0d s=%0d", pi, per, md, s),
                  32'(h), 32'(ex));
            if (md == 0 && s == 1) begin
              wait_rise(t0); wait_rise(t1);
              check($sformatf("R2 R3 period pre=%0d per=%0d", pi, per), 32'(t1 - t0), 32'(tp));
            end
          end
        end
      end
    end

    // R5: disabled output low in inverted mode
    soft_reset();
    wr(PE, 32'd2); wr(SM, 32'd1); wr(CT, cw(0, 0, 0, 1, 1, 0));
    count_high(20, h); check("R5 disabled inverted low", 32'(h), 32'd0);

    // R3: largest prescaler ratio 4096
    soft_reset();
    wr(PE, 32'd0); wr(SM, 32'd1); wr(CT, cw(1, 0, 4095, 1, 0, 0));
    wait_rise(t0); wait_rise(t1);
    check("R3 prescaler 4096", 32'(t1 - t0), 32'd8192);

    // R2: 0xFFFF acts as 0xFFFE
    soft_reset();
    wr(PE, 32'hFFFF); wr(SM, 32'd1); wr(CT, cw(1, 0, 0, 1, 0, 0));
    wait_rise(t0); wait_rise(t1);
    check("R2 period FFFF capped", 32'(t1 - t0), 32'd65536);

    // R8 R6 R10: ordering, full-write drop, last reuse
    soft_reset();
    wr(PE, 32'd10);
    wr(SM, 32'd1); wr(SM, 32'd2); wr(SM, 32'd3); wr(SM, 32'd4); wr(SM, 32'd9);
    rd(ST, d); check("R8 full occupancy and drop flag", d, 32'h44);
    rd(SM, d); check("R10 sample reads zero while disabled", d, 32'h0);
    wr(CT, cw(1, 0, 0, 1, 0, 0));
    capture(80);
    expa = '{1, 2, 3, 4, 4, 0, 0};
    for (int k = 0; k < 5; k++)
      check($sformatf("R6 R8 order period %0d", k), 32'(period_high(12, k)), 32'(expa[k]));
    rd(SM, d); check("R10 sample reads active while enabled", d, 32'd4);
    wr(ST, 32'h40); rd(ST, d); check("R9 full-write flag cleared", d & 32'h40, 32'h0);
    wr(CT, cw(0, 0, 0, 1, 0, 0));
    rd(SM, d); check("R10 sample zero after disable", d, 32'h0);

    // R6: repeat two
    soft_reset();
    wr(PE, 32'd2);
    wr(SM, 32'd1); wr(SM, 32'd2); wr(SM, 32'd3);
    wr(CT, cw(1, 1, 0, 1, 0, 0));
    capture(40);
    expa = '{1, 1, 2, 2, 3, 3, 3};
    for (int k = 0; k < 7; k++)
      check($sformatf("R6 repeat2 period %0d", k), 32'(period_high(4, k)), 32'(expa[k]));

    // R6: repeat eight
    soft_reset();
    wr(PE, 32'd2);
    wr(SM, 32'd1); wr(SM, 32'd3);
    wr(CT, cw(1, 3, 0, 1, 0, 0));
    capture(80);
    check("R6 repeat8 period 7", 32'(period_high(4, 7)), 32'd1);
    check("R6 repeat8 period 8", 32'(period_high(4, 8)), 32'd3);
    check("R6 repeat8 period 15", 32'(period_high(4, 15)), 32'd3);

    // R12: period change at boundary
    soft_reset();
    wr(PE, 32'd2); wr(SM, 32'd1); wr(CT, cw(1, 0, 0, 1, 0, 0));
    wait_rise(t0);
    wr(PE, 32'd5);
    wait_rise(t1); wait_rise(t2);
    check("R12 current period keeps old length", 32'(t1 - t0), 32'd4);
    check("R12 next period uses new length", 32'(t2 - t1), 32'd7);

    // R9: flags
    rd(ST, d); check("R9 rollover compare empty flags", d, 32'h38);
    wr(CT, cw(1, 0, 0, 0, 0, 0));
    wr(ST, 32'h78); rd(ST, d); check("R9 W1C with empty condition held", d, 32'h08);
    repeat (20) @(negedge clk);
    rd(ST, d); check("R7 source off stops rollover", d & 32'h70, 32'h0);
    wr(CT, cw(0, 0, 0, 0, 0, 0));
    wr(ST, 32'h08); rd(ST, d); check("R9 empty flag clears when disabled", d, 32'h0);

    soft_reset();
    wr(PE, 32'd2); wr(SM, 32'd4); wr(CT, cw(1, 0, 0, 1, 0, 0));
    repeat (20) @(negedge clk);
    rd(ST, d); check("R9 no compare when sample exceeds count", d, 32'h18);

    soft_reset();
    wr(SM, 32'd1); wr(SM, 32'd2); wr(SM, 32'd3);
    wr(CT, cw(1, 0, 0, 0, 0, 1));
    repeat (3) @(negedge clk);
    rd(ST, d); check("R9 watermark above occupancy", d, 32'h03);
    wr(CT, cw(1, 0, 0, 0, 0, 3));
    repeat (2) @(negedge clk);
    rd(ST, d); check("R9 watermark reached", d, 32'h0B);

    // R7: source selection
    soft_reset();
    src_tick = 3'b101;
    wr(PE, 32'd2); wr(SM, 32'd2); wr(CT, cw(1, 0, 0, 2, 0, 0));
    count_high(40, h); check("R7 idle source no output", 32'(h), 32'd0);
    rd(ST, d); check("R7 idle source no pop", d, 32'h01);
    src_tick = 3'b111;
    repeat (10) @(negedge clk);
    count_high(40, h); check("R7 source 2 runs", 32'(h), 32'd20);
    src_tick = 3'b111;

    // R11: software reset
    soft_reset();
    wr(PE, 32'd5); wr(SM, 32'd3); wr(CT, cw(1, 1, 3, 1, 1, 2));
    repeat (10) @(negedge clk);
    wr(CT, 32'h8);
    rd(CT, d); check("R11 reset bit reads one", d & 32'h8, 32'h8);
    rd(CT, d); check("R11 ctrl cleared", d, 32'h0);
    rd(ST, d); check("R11 status cleared", d, 32'h0);
    rd(PE, d); check("R11 period restored", d, 32'hFFFE);
    rd(SM, d); check("R11 sample zero", d, 32'h0);
    count_high(10, h); check("R11 output low", 32'(h), 32'd0);

    summary();
    $finish;
  end
endmodule